// File: doc/BRIEF.md
# ATA Task-File Device Engine

This block is the device end of a parallel ATA register interface. The host reaches it through a plain register port, where a block-select bit picks the command block or the control block and a 3-bit offset picks the register inside it. The block holds the task-file registers: sector count, sector number, the two cylinder bytes, drive/head, error, status and device control. It also runs the protocol state machine that sequences drive selection, software reset, non-data commands, PIO data-in, PIO data-out and the interrupt handshake.

Sector data passes through an internal sector buffer of one block. When the engine needs a block loaded from the media or stored to it, it raises a request. The media agent then fills or drains the buffer through its own address, write and read pins and answers with a one-cycle acknowledge. Bus-master DMA data movement is left to a neighbour. For DMA commands the engine publishes the start LBA, the sector count and the direction, holds a ready flag, and waits for a done pulse.

Top module: `ata_taskfile_dev`

## Requirements
- R1: After reset, status (command block offset 7) reads 0x40 (DRDY only), error (offset 1) reads 0x01, and intrq, med_req and dma_ready are low.
- R2: A control-block write to offset 6 with bit 2 set forces the reset state, and status then shows BSY (bit 7). A later control write with bit 2 clear returns status to 0x40 and error to 0x01, and clears the other task-file registers to zero.
- R3: Bit 1 of the device-control register is captured on every control write. While it is set, no command completion and no data-ready step raises intrq.
- R4: A command written to offset 7 in a selected idle state is accepted: status reads 0xC0 in the next cycle and error is cleared. Opcodes 0x10, 0x40, 0x70, 0x91, 0xC6, 0xE0, 0xE7 and 0xEF then complete with status 0x40, error 0x00 and intrq raised.
- R5: Reading status at command-block offset 7 clears a pending intrq and returns to plain selected idle. Reading the alternate status at control-block offset 6 returns the same byte and leaves intrq unchanged.
- R6: A drive-register write (offset 6) whose bit 4 differs from the device number moves to unselected idle and drops intrq. Writing bit 4 back to the device number re-raises intrq if the interrupt is still pending.
- R7: An unsupported opcode, or a read, write or DMA opcode (0x20, 0xC4, 0x30, 0xC5, 0xC8, 0xCA) issued while drive-register bit 6 (LBA) is clear, completes with error 0x04 (abort), status 0x41 (ERR in bit 0) and intrq.
- R8: Opcode 0xF8 loads capacity minus one into the task file: bits 7:0 go to sector number, 15:8 to cylinder low, 23:16 to cylinder high and 27:24 to drive-register bits 3:0.
- R9: For PIO reads (0x20, 0xC4) the engine requests each block from the media (med_dir low) at LBA {drive[3:0], cyl high, cyl low, sector number}, incrementing the LBA per block. After each acknowledge it sets status 0x48 and raises intrq, which a status read clears. Each data-register read (offset 0) then returns the next 16-bit word. After the last word of the last block status is 0x40 with no interrupt.
- R10: For PIO writes (0x30, 0xC5) the first block is ready at once with status 0x48 and no interrupt. After a full block of data-register writes, status shows BSY and DSC (0xD0) and the block is handed to the media with med_dir high. Each later block raises intrq, and the final store completes with status 0x50 and intrq.
- R11: For DMA opcodes 0xC8 (media to host, dma_write low) and 0xCA (host to media, dma_write high), the engine raises dma_ready with status DRQ set. It shows the sector count on xfer_sectors, where a count of 0 means 256. A dma_done pulse then completes the command with DSC set, status 0x50 and intrq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_ctl | input | 1 | Block select: 0 command block, 1 control block |
| host_ofs | input | 3 | Register offset inside the block |
| host_wdata | input | 16 | Write data (16 bits for the data register, low byte otherwise) |
| host_rdata | output | 16 | Read data, valid the cycle after host_rd |
| intrq | output | 1 | Interrupt request to the host |
| med_req | output | 1 | Media request: buffer needs filling or draining |
| med_dir | output | 1 | 0 fill buffer from media, 1 store buffer to media |
| med_ack | input | 1 | One-cycle pulse ending a media request |
| med_we | input | 1 | Media buffer write enable during a fill |
| med_addr | input | WA | Media buffer word address |
| med_wdata | input | 16 | Media buffer write word |
| med_rdata | output | 16 | Buffer word at med_addr, one cycle later |
| xfer_lba | output | 28 | LBA of the current block or DMA start |
| dma_ready | output | 1 | DMA command ready for the bus-master neighbour |
| dma_write | output | 1 | DMA direction: 1 host to media |
| xfer_sectors | output | 9 | Sectors remaining in the command |
| dma_done | input | 1 | Pulse from the DMA neighbour ending the transfer |

## Verification
The hardest situation to reach is a pending interrupt that survives while the drive is deselected and is then raised again on reselection. The stimulus gets there by finishing a command with interrupts enabled, writing the drive register with the other device number without reading status, then selecting again. The multi-block PIO cases are also awkward, because each block boundary needs a media handshake followed by a status read. The bench shrinks the sector to eight words so that several blocks and a 256-sector count stay short.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

  // status register bits
  localparam int ST_BSY  = 7;
  localparam int ST_DRDY = 6;
  localparam int ST_DF   = 5;
  localparam int ST_DSC  = 4;
  localparam int ST_DRQ  = 3;
  localparam int ST_ERR  = 0;

  // device control bits
  localparam int CTL_SRST = 2;
  localparam int CTL_NIEN = 1;

  // drive/head bits
  localparam int DRV_LBA = 6;
  localparam int DRV_DEV = 4;

  // command-block offsets
  localparam logic [2:0] OFS_DATA  = 3'd0;
  localparam logic [2:0] OFS_ERR   = 3'd1;
  localparam logic [2:0] OFS_COUNT = 3'd2;
  localparam logic [2:0] OFS_SECN  = 3'd3;
  localparam logic [2:0] OFS_CYLL  = 3'd4;
  localparam logic [2:0] OFS_CYLH  = 3'd5;
  localparam logic [2:0] OFS_DRIVE = 3'd6;
  localparam logic [2:0] OFS_CMD   = 3'd7;
  localparam logic [2:0] OFS_CTRL  = 3'd6;

  localparam logic [7:0] ERR_ABORT = 8'h04;

  typedef enum logic [3:0] {
    S_IDLE_SEL, S_IDLE_INT, S_IDLE_DESEL, S_EXEC, S_FETCH,
    S_IN_INT, S_IN_XFER, S_OUT_INT, S_OUT_XFER, S_STORE, S_DMA, S_SRST
  } tf_state_t;

  typedef enum logic [2:0] {
    K_NODATA, K_MAXADDR, K_PIO_IN, K_PIO_OUT, K_DMA_IN, K_DMA_OUT, K_ABORT
  } cmd_kind_t;

endpackage

// File: rtl/ata_sector_ram.sv
module ata_sector_ram #(
  parameter int unsigned WORDS = 256,
  localparam int unsigned AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [15:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [15:0]   rdata
);
  logic [15:0] mem [WORDS];

  // one write port and one registered read port, block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ata_cmd_decode.sv
module ata_cmd_decode
  import ata_tf_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic       lba_mode,
  output cmd_kind_t  kind
);
  always_comb begin
    unique case (opcode)
      8'h10, 8'h40, 8'h70, 8'h91,
      8'hC6, 8'hE0, 8'hE7, 8'hEF: kind = K_NODATA;
      8'hF8:                      kind = K_MAXADDR;
      8'h20, 8'hC4:               kind = lba_mode ? K_PIO_IN  : K_ABORT;
      8'h30, 8'hC5:               kind = lba_mode ? K_PIO_OUT : K_ABORT;
      8'hC8:                      kind = lba_mode ? K_DMA_IN  : K_ABORT;
      8'hCA:                      kind = lba_mode ? K_DMA_OUT : K_ABORT;
      default:                    kind = K_ABORT;
    endcase
  end
endmodule

// File: rtl/ata_taskfile_dev.sv
module ata_taskfile_dev
  import ata_tf_pkg::*;
#(
  parameter int unsigned SECTOR_BYTES = 512,
  parameter int unsigned DISK_SECTORS = 2097152,
  parameter bit          DEV_ID       = 1'b0,
  localparam int unsigned WORDS = SECTOR_BYTES / 2,
  localparam int unsigned WA    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic          host_ctl,
  input  logic [2:0]    host_ofs,
  input  logic [15:0]   host_wdata,
  output logic [15:0]   host_rdata,
  output logic          intrq,
  output logic          med_req,
  output logic          med_dir,
  input  logic          med_ack,
  input  logic          med_we,
  input  logic [WA-1:0] med_addr,
  input  logic [15:0]   med_wdata,
  output logic [15:0]   med_rdata,
  output logic [27:0]   xfer_lba,
  output logic          dma_ready,
  output logic          dma_write,
  output logic [8:0]    xfer_sectors,
  input  logic          dma_done
);
  localparam logic [WA-1:0] LAST_WORD = WA'(WORDS - 1);
  localparam logic [27:0]   MAX_LBA   = 28'(DISK_SECTORS - 1);
  localparam logic [7:0]    STAT_INIT = 8'h40;

  tf_state_t   st_q;
  cmd_kind_t   kind_q, kind_dec;
  logic [7:0]  status_q, err_q, count_q, secn_q, cyll_q, cylh_q, drive_q;
  logic        nien_q, pend_q, from_ram_q;
  logic [WA-1:0] widx_q;
  logic [8:0]  left_q;
  logic [27:0] lba_q;
  logic [15:0] rdata_q, ram_q;

  // host strobes
  logic wr_cmdblk, wr_ctl, wr_drive, wr_cmd, wr_data, rd_stat, rd_data;
  logic sel_in, soft_init;
  assign wr_cmdblk = host_wr && !host_ctl;
  assign wr_ctl    = host_wr && host_ctl && (host_ofs == OFS_CTRL);
  assign wr_drive  = wr_cmdblk && (host_ofs == OFS_DRIVE);
  assign wr_cmd    = wr_cmdblk && (host_ofs == OFS_CMD);
  assign wr_data   = wr_cmdblk && (host_ofs == OFS_DATA);
  assign rd_stat   = host_rd && !host_ctl && (host_ofs == OFS_CMD);
  assign rd_data   = host_rd && !host_ctl && (host_ofs == OFS_DATA);
  assign sel_in    = (host_wdata[DRV_DEV] == DEV_ID);
  assign soft_init = wr_ctl && !host_wdata[CTL_SRST] && (st_q == S_SRST);

  logic [27:0] tf_lba;
  logic [8:0]  tf_sectors;
  assign tf_lba     = {drive_q[3:0], cylh_q, cyll_q, secn_q};
  assign tf_sectors = (count_q == 8'd0) ? 9'd256 : {1'b0, count_q};

  ata_cmd_decode u_dec (
    .opcode   (host_wdata[7:0]),
    .lba_mode (drive_q[DRV_LBA]),
    .kind     (kind_dec)
  );

  // sector buffer: host side in PIO phases, media side in fill/store phases
  logic          ram_we;
  logic [WA-1:0] ram_waddr, ram_raddr;
  logic [15:0]   ram_wdata;
  always_comb begin
    if (st_q == S_OUT_XFER) begin
      ram_we    = wr_data;
      ram_waddr = widx_q;
      ram_wdata = host_wdata;
    end else begin
      ram_we    = med_we && (st_q == S_FETCH);
      ram_waddr = med_addr;
      ram_wdata = med_wdata;
    end
    ram_raddr = (st_q == S_STORE) ? med_addr : widx_q;
  end

  ata_sector_ram #(.WORDS(WORDS)) u_buf (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (ram_raddr),
    .rdata (ram_q)
  );

  // interrupt enable capture: survives software reset
  always_ff @(posedge clk) begin
    if (rst)         nien_q <= 1'b0;
    else if (wr_ctl) nien_q <= host_wdata[CTL_NIEN];
  end

  // protocol state machine and task file
  always_ff @(posedge clk) begin
    if (rst || soft_init) begin
      st_q     <= DEV_ID ? S_IDLE_DESEL : S_IDLE_SEL;
      kind_q   <= K_NODATA;
      status_q <= STAT_INIT;
      err_q    <= 8'h01;
      count_q  <= '0;
      secn_q   <= '0;
      cyll_q   <= '0;
      cylh_q   <= '0;
      drive_q  <= '0;
      pend_q   <= 1'b0;
      widx_q   <= '0;
      left_q   <= '0;
      lba_q    <= '0;
    end else if (wr_ctl && host_wdata[CTL_SRST]) begin
      st_q             <= S_SRST;
      status_q[ST_BSY] <= 1'b1;
    end else begin
      if (wr_cmdblk) begin
        case (host_ofs)
          OFS_COUNT: count_q <= host_wdata[7:0];
          OFS_SECN:  secn_q  <= host_wdata[7:0];
          OFS_CYLL:  cyll_q  <= host_wdata[7:0];
          OFS_CYLH:  cylh_q  <= host_wdata[7:0];
          OFS_DRIVE: drive_q <= host_wdata[7:0];
          default: ;
        endcase
      end

      case (st_q)
        S_IDLE_SEL, S_IDLE_INT: begin
          if (wr_drive && !sel_in) begin
            st_q <= S_IDLE_DESEL;          // pending flag kept for reselect
          end else if (st_q == S_IDLE_INT && (rd_stat || nien_q)) begin
            st_q   <= S_IDLE_SEL;
            pend_q <= 1'b0;
          end else if (wr_cmd) begin
            pend_q           <= 1'b0;
            kind_q           <= kind_dec;
            status_q[ST_BSY] <= 1'b1;
            status_q[ST_DRQ] <= 1'b0;
            status_q[ST_DF]  <= 1'b0;
            status_q[ST_ERR] <= 1'b0;
            err_q            <= 8'h00;
            left_q           <= tf_sectors;
            lba_q            <= tf_lba;
            widx_q           <= '0;
            st_q             <= S_EXEC;
          end
        end

        S_IDLE_DESEL: begin
          if (wr_drive && sel_in) begin
            if (pend_q && !nien_q) st_q <= S_IDLE_INT;
            else begin
              st_q   <= S_IDLE_SEL;
              pend_q <= 1'b0;
            end
          end
        end

        S_EXEC: begin
          case (kind_q)
            K_PIO_IN: st_q <= S_FETCH;
            K_PIO_OUT: begin
              status_q[ST_BSY] <= 1'b0;
              status_q[ST_DRQ] <= 1'b1;
              st_q             <= S_OUT_XFER;   // no interrupt before block one
            end
            K_DMA_IN, K_DMA_OUT: begin
              status_q[ST_BSY] <= 1'b0;
              status_q[ST_DRQ] <= 1'b1;
              st_q             <= S_DMA;
            end
            default: begin
              if (kind_q == K_MAXADDR) begin
                secn_q       <= MAX_LBA[7:0];
                cyll_q       <= MAX_LBA[15:8];
                cylh_q       <= MAX_LBA[23:16];
                drive_q[3:0] <= MAX_LBA[27:24];
              end
              if (kind_q == K_ABORT) begin
                err_q            <= ERR_ABORT;
                status_q[ST_ERR] <= 1'b1;
              end
              status_q[ST_BSY] <= 1'b0;
              status_q[ST_DRQ] <= 1'b0;
              st_q             <= nien_q ? S_IDLE_SEL : S_IDLE_INT;
              pend_q           <= !nien_q;
            end
          endcase
        end

        S_FETCH: begin
          if (med_ack) begin
            status_q[ST_BSY] <= 1'b0;
            status_q[ST_DRQ] <= 1'b1;
            widx_q           <= '0;
            st_q             <= nien_q ? S_IN_XFER : S_IN_INT;
            pend_q           <= !nien_q;
          end
        end

        S_IN_INT: begin
          if (rd_stat) begin
            st_q   <= S_IN_XFER;
            pend_q <= 1'b0;
          end
        end

        S_IN_XFER: begin
          if (rd_data) begin
            widx_q <= widx_q + 1'b1;
            if (widx_q == LAST_WORD) begin
              widx_q           <= '0;
              lba_q            <= lba_q + 28'd1;
              left_q           <= left_q - 9'd1;
              status_q[ST_DRQ] <= 1'b0;
              if (left_q == 9'd1) begin
                st_q <= S_IDLE_SEL;                 // last block: quiet finish
              end else begin
                status_q[ST_BSY] <= 1'b1;
                st_q             <= S_FETCH;
              end
            end
          end
        end

        S_OUT_INT: begin
          if (rd_stat) begin
            st_q   <= S_OUT_XFER;
            pend_q <= 1'b0;
          end
        end

        S_OUT_XFER: begin
          if (wr_data) begin
            widx_q <= widx_q + 1'b1;
            if (widx_q == LAST_WORD) begin
              widx_q           <= '0;
              status_q[ST_BSY] <= 1'b1;
              status_q[ST_DSC] <= 1'b1;
              status_q[ST_DRQ] <= 1'b0;
              st_q             <= S_STORE;
            end
          end
        end

        S_STORE: begin
          if (med_ack) begin
            lba_q            <= lba_q + 28'd1;
            left_q           <= left_q - 9'd1;
            status_q[ST_BSY] <= 1'b0;
            pend_q           <= !nien_q;
            if (left_q == 9'd1) begin
              st_q <= nien_q ? S_IDLE_SEL : S_IDLE_INT;
            end else begin
              status_q[ST_DRQ] <= 1'b1;
              st_q             <= nien_q ? S_OUT_XFER : S_OUT_INT;
            end
          end
        end

        S_DMA: begin
          if (dma_done) begin
            status_q[ST_BSY] <= 1'b0;
            status_q[ST_DRQ] <= 1'b0;
            status_q[ST_DSC] <= 1'b1;
            st_q             <= nien_q ? S_IDLE_SEL : S_IDLE_INT;
            pend_q           <= !nien_q;
          end
        end

        default: ;   // S_SRST waits for the clearing control write
      endcase
    end
  end

  // host read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q    <= '0;
      from_ram_q <= 1'b0;
    end else if (host_rd) begin
      from_ram_q <= rd_data;
      if (host_ctl) rdata_q <= {8'h00, status_q};
      else begin
        case (host_ofs)
          OFS_ERR:   rdata_q <= {8'h00, err_q};
          OFS_COUNT: rdata_q <= {8'h00, count_q};
          OFS_SECN:  rdata_q <= {8'h00, secn_q};
          OFS_CYLL:  rdata_q <= {8'h00, cyll_q};
          OFS_CYLH:  rdata_q <= {8'h00, cylh_q};
          OFS_DRIVE: rdata_q <= {8'h00, drive_q};
          OFS_CMD:   rdata_q <= {8'h00, status_q};
          default:   rdata_q <= '0;
        endcase
      end
    end
  end

  assign host_rdata   = from_ram_q ? ram_q : rdata_q;
  assign med_rdata    = ram_q;
  assign intrq        = pend_q && (st_q != S_IDLE_DESEL);
  assign med_req      = (st_q == S_FETCH) || (st_q == S_STORE);
  assign med_dir      = (st_q == S_STORE);
  assign xfer_lba     = lba_q;
  assign xfer_sectors = left_q;
  assign dma_ready    = (st_q == S_DMA);
  assign dma_write    = (kind_q == K_DMA_OUT);

  // R2: the reset state always reports busy
  a_r2_srst_busy: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_SRST) |-> status_q[ST_BSY]);

  // R9 / R10: busy and data request never show together
  a_r10_bsy_drq_excl: assert property (@(posedge clk) disable iff (rst)
    !(status_q[ST_BSY] && status_q[ST_DRQ]));

  // R9: a media request is only outstanding while busy
  a_r9_req_busy: assert property (@(posedge clk) disable iff (rst)
    med_req |-> status_q[ST_BSY]);

  // R3: an interrupt only rises when interrupts were enabled
  a_r3_nien_quiet: assert property (@(posedge clk) disable iff (rst)
    $rose(intrq) |-> $past(!nien_q));

  // R6: deselecting from interrupt idle drops the request line
  a_r6_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_IDLE_INT && wr_drive && !sel_in) |=> !intrq);

  // R11: the DMA handoff is offered with DRQ set
  a_r11_dma_drq: assert property (@(posedge clk) disable iff (rst)
    dma_ready |-> status_q[ST_DRQ]);

endmodule

// File: tb/ata_taskfile_dev_tb_top.sv
module ata_taskfile_dev_tb_top;
  localparam int unsigned SB    = 16;
  localparam int unsigned WORDS = SB / 2;
  localparam int unsigned WA    = $clog2(WORDS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr = 0, host_rd = 0, host_ctl = 0;
  logic [2:0]  host_ofs = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic intrq, med_req, med_dir, dma_ready, dma_write;
  logic med_ack = 0, med_we = 0, dma_done = 0;
  logic [WA-1:0] med_addr = '0;
  logic [15:0] med_wdata = '0, med_rdata;
  logic [27:0] xfer_lba;
  logic [8:0]  xfer_sectors;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;   // 50 MHz

  ata_taskfile_dev #(.SECTOR_BYTES(SB), .DISK_SECTORS(28'h3ABCDEF), .DEV_ID(1'b0)) dut_i (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd), .host_ctl(host_ctl),
    .host_ofs(host_ofs), .host_wdata(host_wdata), .host_rdata(host_rdata), .intrq(intrq),
    .med_req(med_req), .med_dir(med_dir), .med_ack(med_ack), .med_we(med_we),
    .med_addr(med_addr), .med_wdata(med_wdata), .med_rdata(med_rdata), .xfer_lba(xfer_lba),
    .dma_ready(dma_ready), .dma_write(dma_write), .xfer_sectors(xfer_sectors),
    .dma_done(dma_done)
  );

  // {opcode, drive value, expected error}
  localparam logic [23:0] CMD_TAB [0:10] = '{
    {8'h10, 8'hA0, 8'h00}, {8'h40, 8'hA0, 8'h00}, {8'h70, 8'hA0, 8'h00},
    {8'h91, 8'hA0, 8'h00}, {8'hC6, 8'hA0, 8'h00}, {8'hE0, 8'hA0, 8'h00},
    {8'hE7, 8'hA0, 8'h00}, {8'hEF, 8'hA0, 8'h00}, {8'h00, 8'hE0, 8'h04},
    {8'hEC, 8'hE0, 8'h04}, {8'h20, 8'hA0, 8'h04}
  };

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", what, act, exp);
    end
  endtask

  // all bus tasks start and end just after a falling edge
  task automatic wr(input logic ctl, input logic [2:0] ofs, input logic [15:0] d);
    host_wr = 1; host_ctl = ctl; host_ofs = ofs; host_wdata = d;
    @(negedge clk);
    host_wr = 0; host_ctl = 0;
  endtask

  task automatic rd(input logic ctl, input logic [2:0] ofs, output logic [15:0] d);
    host_rd = 1; host_ctl = ctl; host_ofs = ofs;
    @(negedge clk);
    host_rd = 0; host_ctl = 0;
    d = host_rdata;
  endtask

  function automatic logic [15:0] pat(input logic [27:0] lba, input int i);
    return {lba[7:0], 8'(i)} ^ 16'h5A00;
  endfunction

  task automatic media_fill(input logic [27:0] exp_lba, input string tag);
    while (!med_req) @(negedge clk);
    check({tag, " fill direction"}, med_dir, 0);
    check({tag, " fill lba"}, xfer_lba, exp_lba);
    for (int i = 0; i < WORDS; i++) begin
      med_we = 1; med_addr = WA'(i); med_wdata = pat(xfer_lba, i);
      @(negedge clk);
    end
    med_we = 0; med_ack = 1;
    @(negedge clk);
    med_ack = 0;
  endtask

  task automatic media_store(input logic [27:0] exp_lba, input logic [15:0] base);
    while (!med_req) @(negedge clk);
    check("R10 store direction", med_dir, 1);
    check("R10 store lba", xfer_lba, exp_lba);
    for (int i = 0; i < WORDS; i++) begin
      med_addr = WA'(i);
      @(negedge clk);
      check("R10 stored word", med_rdata, base + 16'(i));
    end
    med_ack = 1;
    @(negedge clk);
    med_ack = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    rd(0, 3'd7, d); check("R1 status", d, 16'h40);
    rd(0, 3'd1, d); check("R1 error", d, 16'h01);
    check("R1 intrq", intrq, 0);
    check("R1 med_req", med_req, 0);
    check("R1 dma_ready", dma_ready, 0);

    // R4 / R7 table of commands
    foreach (CMD_TAB[k]) begin
      wr(0, 3'd6, {8'h00, CMD_TAB[k][15:8]});
      wr(0, 3'd7, {8'h00, CMD_TAB[k][23:16]});
      rd(1, 3'd6, d); check("R4 busy on accept", d, 16'hC0);
      @(negedge clk);
      check("R4 R7 intrq on completion", intrq, 1);
      rd(0, 3'd1, d); check("R4 R7 error", d, {8'h00, CMD_TAB[k][7:0]});
      rd(0, 3'd7, d);
      check("R4 R7 status", d, (CMD_TAB[k][7:0] != 0) ? 16'h41 : 16'h40);
      check("R5 status read clears intrq", intrq, 0);
    end

    // R5 alternate status keeps interrupt; R6 deselect / reselect
    wr(0, 3'd7, 16'h70);
    repeat (2) @(negedge clk);
    rd(1, 3'd6, d); check("R5 alt status", d, 16'h40);
    check("R5 alt status keeps intrq", intrq, 1);
    wr(0, 3'd6, 16'h10);
    check("R6 deselect drops intrq", intrq, 0);
    wr(0, 3'd6, 16'h00);
    check("R6 reselect re-raises intrq", intrq, 1);
    rd(0, 3'd7, d);
    check("R5 status read clears", intrq, 0);

    // R3 nIEN suppresses completion interrupt
    wr(1, 3'd6, 16'h02);
    wr(0, 3'd7, 16'h40);
    repeat (2) @(negedge clk);
    check("R3 no intrq with nIEN", intrq, 0);
    rd(1, 3'd6, d); check("R3 status", d, 16'h40);
    wr(1, 3'd6, 16'h00);

    // R8 read native max
    wr(0, 3'd6, 16'hE0);
    wr(0, 3'd7, 16'hF8);
    repeat (2) @(negedge clk);
    rd(0, 3'd3, d); check("R8 sector number", d, 16'hEE);
    rd(0, 3'd4, d); check("R8 cyl low", d, 16'hCD);
    rd(0, 3'd5, d); check("R8 cyl high", d, 16'hAB);
    rd(0, 3'd6, d); check("R8 drive head", d, 16'hE3);
    rd(0, 3'd7, d);

    // R9 PIO data-in, two blocks from LBA 0x1002010
    wr(0, 3'd2, 16'h02); wr(0, 3'd3, 16'h10); wr(0, 3'd4, 16'h20);
    wr(0, 3'd5, 16'h00); wr(0, 3'd6, 16'hE1);
    wr(0, 3'd7, 16'h20);
    rd(1, 3'd6, d); check("R9 busy on accept", d, 16'hC0);
    for (int b = 0; b < 2; b++) begin
      media_fill(28'h1002010 + 28'(b), "R9");
      check("R9 intrq per block", intrq, 1);
      rd(1, 3'd6, d); check("R9 drq status", d, 16'h48);
      rd(0, 3'd7, d);
      check("R9 status read clears", intrq, 0);
      for (int i = 0; i < WORDS; i++) begin
        rd(0, 3'd0, d);
        check("R9 data word", d, pat(28'h1002010 + 28'(b), i));
      end
    end
    rd(1, 3'd6, d); check("R9 final status", d, 16'h40);
    check("R9 no final intrq", intrq, 0);

    // R10 PIO data-out, two blocks at LBA 5
    wr(0, 3'd2, 16'h02); wr(0, 3'd3, 16'h05); wr(0, 3'd4, 16'h00);
    wr(0, 3'd6, 16'hE0);
    wr(0, 3'd7, 16'h30);
    @(negedge clk);
    rd(1, 3'd6, d); check("R10 first block ready", d, 16'h48);
    check("R10 no intrq first block", intrq, 0);
    for (int i = 0; i < WORDS; i++) wr(0, 3'd0, 16'h1000 + 16'(i));
    rd(1, 3'd6, d); check("R10 busy+dsc after block", d, 16'hD0);
    media_store(28'd5, 16'h1000);
    check("R10 intrq second block", intrq, 1);
    rd(1, 3'd6, d); check("R10 second block status", d, 16'h58);
    rd(0, 3'd7, d);
    check("R10 status read clears", intrq, 0);
    for (int i = 0; i < WORDS; i++) wr(0, 3'd0, 16'h2000 + 16'(i));
    media_store(28'd6, 16'h2000);
    check("R10 completion intrq", intrq, 1);
    rd(0, 3'd7, d); check("R10 final status", d, 16'h50);

    // R11 DMA host-to-media with count 0
    wr(0, 3'd2, 16'h00); wr(0, 3'd3, 16'h07);
    wr(0, 3'd7, 16'hCA);
    @(negedge clk);
    check("R11 dma_ready", dma_ready, 1);
    check("R11 dma_write", dma_write, 1);
    check("R11 count zero is 256", xfer_sectors, 256);
    check("R11 dma lba", xfer_lba, 28'd7);
    rd(1, 3'd6, d); check("R11 drq status", d, 16'h58);
    dma_done = 1; @(negedge clk); dma_done = 0;
    check("R11 completion intrq", intrq, 1);
    check("R11 dma_ready drops", dma_ready, 0);
    rd(0, 3'd7, d); check("R11 final status", d, 16'h50);
    wr(0, 3'd2, 16'h03);
    wr(0, 3'd7, 16'hC8);
    @(negedge clk);
    check("R11 read dma direction", dma_write, 0);
    check("R11 sector count", xfer_sectors, 3);
    dma_done = 1; @(negedge clk); dma_done = 0;
    rd(0, 3'd7, d);

    // R2 software reset
    wr(0, 3'd3, 16'h55);
    wr(1, 3'd6, 16'h04);
    rd(1, 3'd6, d); check("R2 busy in reset", d[7], 1);
    wr(1, 3'd6, 16'h00);
    rd(0, 3'd7, d); check("R2 status after clear", d, 16'h40);
    rd(0, 3'd1, d); check("R2 error after clear", d, 16'h01);
    rd(0, 3'd3, d); check("R2 sector number cleared", d, 16'h00);
    check("R2 intrq low", intrq, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule